// File: doc/BRIEF.md
# Two-Wiper Serial Potentiometer Controller

This block is the digital front end of a dual digital potentiometer. It listens on a two-wire serial bus as a target device. It holds two 8-bit wiper codes and drives two latched general-purpose output pins. It also produces a shutdown level and applies a midscale preset on request. The bus clock and data lines are brought into a fast system clock domain through two-flop synchronizers. The block drives the data line only through an open-drain enable, so when `sda_oe` is high the line is pulled low.

A write transaction has three bytes: an address byte, an instruction byte and a data byte. The target acknowledges each of them. The instruction byte chooses which wiper the data byte lands in. The same byte carries the preset, shutdown and output-pin fields. A read transaction has no register pointer. It sends back the wiper that the most recent instruction byte chose, and it repeats that byte for as long as the controller acknowledges. Two strap inputs set the low bits of the target address, so four of these blocks can share one bus.

Top module: `dualpot_i2c_ctrl`

## Requirements
- R1: The target acknowledges an address byte only when its seven upper bits equal 0b01011 followed by `strap_i[1:0]`. Bit 0 of the address byte selects the direction: 1 means read and 0 means write.
- R2: After an address that does not match, the target drives no acknowledge. It then leaves every output unchanged for the rest of the transaction, until the next start condition.
- R3: Each field of the instruction byte takes effect when the eighth bit of that byte is sampled:
  - bit 7 selects the wiper (0 = `wiper_a`, 1 = `wiper_b`);
  - bit 6 requests the midscale preset;
  - bit 5 is the shutdown bit;
  - bit 4 drives `gpo_o[0]`;
  - bit 3 drives `gpo_o[1]`;
  - bits 2:0 are ignored.
- R4: The data byte is received MSB first. It is written into the selected wiper when its eighth bit is sampled.
- R5: When the instruction byte has bit 6 set, the selected wiper becomes 0x80 and the data byte that follows is ignored.
- R6: A read sends back the wiper selected by the latest instruction byte, MSB first. `sda_oe` changes only while SCL is low.
- R7: `shutdown_o` is high when the stored shutdown bit is 1 or when `shdn_pin_n` is 0.
- R8: For each accepted byte of a write, the target drives SDA low during the ninth clock. It releases SDA after the falling edge of that clock.
- R9: After reset, both wipers are 0x80, `gpo_o` is 0, the shutdown bit is 0 and `wiper_a` is selected for reads.
- R10: A start condition in the middle of a transaction, including a repeated start, restarts address reception.
- R11: `sda_oe` is 0 whenever the bus is idle or the target is ignoring traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When high, pull the data line low |
| strap_i | input | 2 | Address strap levels |
| shdn_pin_n | input | 1 | Active-low hardware shutdown |
| wiper_a | output | 8 | First wiper code |
| wiper_b | output | 8 | Second wiper code |
| shutdown_o | output | 1 | Effective shutdown level |
| gpo_o | output | 2 | Latched general-purpose outputs |

## Verification
The embedded properties watch four things on every cycle:
- `sda_oe` toggles only in the low phase of the synchronized clock.
- The target stays silent while idle or while ignoring traffic.
- Wiper and output-pin registers move only after a byte strobe.
- A start always returns the engine to address reception.

Other behaviours need whole transactions, so only the bench scenarios show them. These are:
- address matching against the straps;
- the acknowledge level the controller actually sees;
- the byte returned by a read after a repeated start;
- the data byte being discarded when the preset bit is set.

The bench compares all of these against a reference model of the registers.

// File: rtl/dp_pkg.sv
package dp_pkg;
  // Transaction engine states.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INSTR,
    ST_DATA,
    ST_READ,
    ST_SKIP
  } link_st_t;

  // Position within a byte: data bits, waiting for the ninth clock, ninth clock.
  typedef enum logic [1:0] {
    SL_BITS,
    SL_ACK_WAIT,
    SL_ACK_DRV,
    SL_HOST_ACK
  } slot_t;

  // Instruction byte field positions.
  localparam int SEL_BIT = 7;
  localparam int MID_BIT = 6;
  localparam int SD_BIT  = 5;
  localparam int G0_BIT  = 4;
  localparam int G1_BIT  = 3;
endpackage

// File: rtl/dp_sync.sv
module dp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dp_busmon.sv
module dp_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // Data edges while the clock stays high mark frame boundaries.
  always_comb begin
    scl_hi    = scl_q;
    scl_rise  = !scl_q && scl_s;
    scl_fall  = scl_q && !scl_s;
    bus_start = scl_q && scl_s && sda_q && !sda_s;
    bus_stop  = scl_q && scl_s && !sda_q && sda_s;
  end
endmodule

// File: rtl/dp_link.sv
module dp_link
  import dp_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          STRAP_W   = 2,
  parameter int          ADDR_HI_W = 5,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 5'b01011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_hi,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               bus_start,
  input  logic               bus_stop,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DATA_W-1:0]  rd_val,
  output logic               sda_oe,
  output logic               instr_stb,
  output logic               data_stb,
  output logic [DATA_W-1:0]  rx_byte
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  link_st_t            state_q, state_d;
  slot_t               slot_q, slot_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [DATA_W-1:0]   rx_q, rx_d, tx_q, tx_d, rx_next;
  logic                oe_q, oe_d, rd_q, rd_d;
  logic                bit_rise, last_bit, addr_hit, rx_phase;

  always_comb begin
    rx_next   = {rx_q[DATA_W-2:0], sda_s};
    last_bit  = (cnt_q == CNT_W'(DATA_W - 1));
    bit_rise  = scl_rise && (slot_q == SL_BITS);
    addr_hit  = (rx_next[DATA_W-1:1] == {ADDR_HI, strap});
    rx_phase  = bit_rise && last_bit;
    instr_stb = rx_phase && (state_q == ST_INSTR);
    data_stb  = rx_phase && (state_q == ST_DATA);
    rx_byte   = rx_next;
  end

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    oe_d    = oe_q;
    rd_d    = rd_q;
    if (bus_start) begin
      state_d = ST_ADDR;
      slot_d  = SL_BITS;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (bus_stop) begin
      state_d = ST_IDLE;
      slot_d  = SL_BITS;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_INSTR, ST_DATA: begin
          if (bit_rise) begin
            rx_d  = rx_next;
            cnt_d = cnt_q + CNT_W'(1);
            if (last_bit) begin
              if (state_q == ST_ADDR && !addr_hit) begin
                state_d = ST_SKIP;
              end else begin
                slot_d = SL_ACK_WAIT;
                if (state_q == ST_ADDR) rd_d = sda_s;
              end
            end
          end else if (scl_fall && slot_q == SL_ACK_WAIT) begin
            oe_d   = 1'b1;
            slot_d = SL_ACK_DRV;
          end else if (scl_fall && slot_q == SL_ACK_DRV) begin
            oe_d   = 1'b0;
            slot_d = SL_BITS;
            cnt_d  = '0;
            if (state_q == ST_ADDR) begin
              if (rd_q) begin
                state_d = ST_READ;
                tx_d    = rd_val;
                oe_d    = !rd_val[DATA_W-1];
              end else begin
                state_d = ST_INSTR;
              end
            end else if (state_q == ST_INSTR) begin
              state_d = ST_DATA;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_READ: begin
          if (scl_rise && slot_q == SL_BITS) begin
            cnt_d = cnt_q + CNT_W'(1);
            if (last_bit) slot_d = SL_ACK_WAIT;
          end else if (scl_rise && slot_q == SL_HOST_ACK) begin
            if (sda_s) state_d = ST_SKIP;
          end else if (scl_fall) begin
            if (slot_q == SL_BITS) begin
              tx_d = {tx_q[DATA_W-2:0], 1'b0};
              oe_d = !tx_q[DATA_W-2];
            end else if (slot_q == SL_ACK_WAIT) begin
              oe_d   = 1'b0;
              slot_d = SL_HOST_ACK;
            end else if (slot_q == SL_HOST_ACK) begin
              tx_d   = rd_val;
              oe_d   = !rd_val[DATA_W-1];
              cnt_d  = '0;
              slot_d = SL_BITS;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= SL_BITS;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      oe_q    <= oe_d;
      rd_q    <= rd_d;
    end
  end

  assign sda_oe = oe_q;

  // R6
  sda_lowphase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_hi);
  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_SKIP) |-> !oe_q);
  // R10
  restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (state_q == ST_ADDR && slot_q == SL_BITS && cnt_q == '0));
  // R2
  miss_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && rx_phase && !addr_hit) |=> (state_q == ST_SKIP && !oe_q));
endmodule

// File: rtl/dp_regs.sv
module dp_regs
  import dp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_stb,
  input  logic              data_stb,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] wiper_a,
  output logic [DATA_W-1:0] wiper_b,
  output logic              sd_bit,
  output logic [1:0]        gpo,
  output logic [DATA_W-1:0] rd_val
);
  localparam int                NW      = 2;
  localparam logic [DATA_W-1:0] MID_VAL = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] wiper_q [NW];
  logic              sel_q, sel_d, sd_q, sd_d, mid_q, mid_d;
  logic [1:0]        gpo_q, gpo_d;

  for (genvar i = 0; i < NW; i++) begin : g_wiper
    logic [DATA_W-1:0] w_d;
    logic              w_en;
    always_comb begin
      w_en = 1'b0;
      w_d  = wiper_q[i];
      if (instr_stb && rx_byte[MID_BIT] && (rx_byte[SEL_BIT] == 1'(i))) begin
        w_en = 1'b1;
        w_d  = MID_VAL;
      end else if (data_stb && !mid_q && (sel_q == 1'(i))) begin
        w_en = 1'b1;
        w_d  = rx_byte;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    wiper_q[i] <= MID_VAL;
      else if (w_en) wiper_q[i] <= w_d;
    end

    // R4
    wiper_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wiper_q[i]) |-> $past(instr_stb || data_stb));
    // R5
    midscale_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_stb && rx_byte[MID_BIT] && rx_byte[SEL_BIT] == 1'(i)) |=> wiper_q[i] == MID_VAL);
  end

  always_comb begin
    sel_d = rx_byte[SEL_BIT];
    sd_d  = rx_byte[SD_BIT];
    mid_d = rx_byte[MID_BIT];
    gpo_d = {rx_byte[G1_BIT], rx_byte[G0_BIT]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      sd_q  <= 1'b0;
      mid_q <= 1'b0;
      gpo_q <= '0;
    end else if (instr_stb) begin
      sel_q <= sel_d;
      sd_q  <= sd_d;
      mid_q <= mid_d;
      gpo_q <= gpo_d;
    end
  end

  assign wiper_a = wiper_q[0];
  assign wiper_b = wiper_q[1];
  assign sd_bit  = sd_q;
  assign gpo     = gpo_q;
  assign rd_val  = wiper_q[sel_q];

  // R3
  gpo_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpo_q) |-> $past(instr_stb));
endmodule

// File: rtl/dualpot_i2c_ctrl.sv
module dualpot_i2c_ctrl #(
  parameter int DATA_W      = 8,
  parameter int STRAP_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               shdn_pin_n,
  output logic [DATA_W-1:0]  wiper_a,
  output logic [DATA_W-1:0]  wiper_b,
  output logic               shutdown_o,
  output logic [1:0]         gpo_o
);
  localparam int ADDR_HI_W = DATA_W - 1 - STRAP_W;

  logic rst_sn, scl_s, sda_s;
  logic scl_hi, scl_rise, scl_fall, bus_start, bus_stop;
  logic instr_stb, data_stb, sd_bit;
  logic [DATA_W-1:0] rx_byte, rd_val;

  // Reset asserts at once and releases on a clock edge.
  dp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sn));
  dp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl (
    .clk(clk), .rst_n(rst_sn), .d(scl_i), .q(scl_s));
  dp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
    .clk(clk), .rst_n(rst_sn), .d(sda_i), .q(sda_s));

  dp_busmon u_mon (
    .clk(clk), .rst_n(rst_sn), .scl_s(scl_s), .sda_s(sda_s),
    .scl_hi(scl_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop));

  dp_link #(
    .DATA_W(DATA_W), .STRAP_W(STRAP_W), .ADDR_HI_W(ADDR_HI_W),
    .ADDR_HI(ADDR_HI_W'(5'b01011))
  ) u_link (
    .clk(clk), .rst_n(rst_sn), .scl_hi(scl_hi), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .strap(strap_i), .rd_val(rd_val), .sda_oe(sda_oe),
    .instr_stb(instr_stb), .data_stb(data_stb), .rx_byte(rx_byte));

  dp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sn), .instr_stb(instr_stb), .data_stb(data_stb),
    .rx_byte(rx_byte), .wiper_a(wiper_a), .wiper_b(wiper_b),
    .sd_bit(sd_bit), .gpo(gpo_o), .rd_val(rd_val));

  // R7: the hardware pin and the stored bit each force shutdown.
  assign shutdown_o = sd_bit | ~shdn_pin_n;
endmodule

// File: tb/sim_dualpot_i2c_ctrl.sv
module sim_dualpot_i2c_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int QCLK       = 8;

  logic       clk = 1'b0;
  logic       rst_n, scl_m, sda_m, shdn_n;
  logic [1:0] strap;
  logic       sda_oe, shutdown;
  logic [7:0] wa, wb;
  logic [1:0] gpo;
  wire        sda_line = sda_m & ~sda_oe;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic [7:0] m_a, m_b;
  logic       m_sel, m_sd, m_mid;
  logic [1:0] m_gpo;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualpot_i2c_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .shdn_pin_n(shdn_n), .wiper_a(wa), .wiper_b(wb),
    .shutdown_o(shutdown), .gpo_o(gpo));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick_q();
    repeat (QCLK) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick_q();
    scl_m = 1'b1; tick_q();
    sda_m = 1'b0; tick_q();
    scl_m = 1'b0; tick_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick_q();
    scl_m = 1'b1; tick_q();
    sda_m = 1'b1; tick_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick_q();
      scl_m = 1'b1; tick_q(); tick_q();
      scl_m = 1'b0; tick_q();
    end
    sda_m = 1'b1; tick_q();
    scl_m = 1'b1; tick_q();
    ack = ~sda_line; tick_q();
    scl_m = 1'b0; tick_q();
  endtask

  task automatic recv_byte(output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick_q();
      scl_m = 1'b1; tick_q();
      d[i] = sda_line; tick_q();
      scl_m = 1'b0;
    end
    tick_q();
    sda_m = 1'b1; tick_q();   // no acknowledge from the controller
    scl_m = 1'b1; tick_q(); tick_q();
    scl_m = 1'b0; tick_q();
  endtask

  function automatic logic [6:0] good_addr();
    return {5'b01011, strap};
  endfunction

  function automatic logic [7:0] read_exp();
    return m_sel ? m_b : m_a;
  endfunction

  task automatic apply_instr(input logic [7:0] b);
    m_sel = b[7]; m_mid = b[6]; m_sd = b[5]; m_gpo = {b[3], b[4]};
    if (b[6]) begin
      if (b[7]) m_b = 8'h80; else m_a = 8'h80;
    end
  endtask

  task automatic apply_data(input logic [7:0] d);
    if (!m_mid) begin
      if (m_sel) m_b = d; else m_a = d;
    end
  endtask

  task automatic check_outputs();
    check(wa == m_a, "R4 wiper_a", wa, m_a);
    check(wb == m_b, "R4 wiper_b", wb, m_b);
    check(gpo == m_gpo, "R3 gpo", gpo, m_gpo);
    check(shutdown == (m_sd | ~shdn_n), "R7 shutdown", shutdown, m_sd | ~shdn_n);
    check(sda_oe == 1'b0, "R11 released", sda_oe, 0);
  endtask

  task automatic do_write(input logic [6:0] a7, input logic [7:0] ins, input logic [7:0] d);
    logic ack;
    bit   hit = (a7 == good_addr());
    bus_start();
    send_byte({a7, 1'b0}, ack);
    check(ack == hit, hit ? "R1 addr ack" : "R2 addr nack", ack, hit);
    send_byte(ins, ack);
    check(ack == hit, hit ? "R8 instr ack" : "R2 ignored", ack, hit);
    if (hit) apply_instr(ins);
    send_byte(d, ack);
    check(ack == hit, hit ? "R8 data ack" : "R2 ignored", ack, hit);
    if (hit) apply_data(d);
    bus_stop();
    check_outputs();
  endtask

  task automatic do_read(input logic [6:0] a7);
    logic ack;
    logic [7:0] d;
    bit hit = (a7 == good_addr());
    bus_start();
    send_byte({a7, 1'b1}, ack);
    check(ack == hit, "R1 read addr ack", ack, hit);
    if (hit) begin
      recv_byte(d);
      check(d == read_exp(), "R6 read data", d, read_exp());
    end
    bus_stop();
    check(sda_oe == 1'b0, "R11 after read", sda_oe, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    void'($urandom(32'd4242));
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; shdn_n = 1'b1; strap = 2'b10;
    m_a = 8'h80; m_b = 8'h80; m_sel = 0; m_sd = 0; m_mid = 0; m_gpo = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 reset state
    check(wa == 8'h80 && wb == 8'h80, "R9 wipers", {wa, wb}, 16'h8080);
    check(gpo == 2'b00 && shutdown == 1'b0, "R9 gpo/sd", {gpo, shutdown}, 0);
    check(sda_oe == 1'b0, "R9 sda_oe", sda_oe, 0);
    do_read(good_addr());                           // R9 selects wiper_a

    // R4 / R6 directed writes and reads
    do_write(good_addr(), 8'b0001_0111, 8'h3C);     // wiper_a, O1=1, dont-care bits set
    do_read(good_addr());
    do_write(good_addr(), 8'b1010_1000, 8'h55);     // wiper_b, shutdown, O2
    do_read(good_addr());
    // R5 midscale with a data byte that must be dropped
    do_write(good_addr(), 8'b1100_0000, 8'h11);
    check(wb == 8'h80, "R5 data dropped", wb, 8'h80);
    // R7 hardware pin
    shdn_n = 1'b0; repeat (2) @(negedge clk);
    check(shutdown == 1'b1, "R7 pin forces", shutdown, 1);
    shdn_n = 1'b1; repeat (2) @(negedge clk);
    check(shutdown == m_sd, "R7 pin released", shutdown, m_sd);
    // R1 wrong fixed part and R2 wrong strap
    do_write({5'b01010, strap}, 8'h18, 8'hAA);
    do_write({5'b01011, ~strap}, 8'h18, 8'hAA);
    // R10 repeated start: instruction only, then read back the new choice
    bus_start();
    send_byte({good_addr(), 1'b0}, ack);
    check(ack, "R10 addr ack", ack, 1);
    send_byte(8'b1001_0000, ack);
    apply_instr(8'b1001_0000);
    bus_start();
    send_byte({good_addr(), 1'b1}, ack);
    check(ack, "R10 restart ack", ack, 1);
    recv_byte(d);
    check(d == read_exp(), "R10 read after restart", d, read_exp());
    bus_stop();
    check_outputs();

    // random mix
    for (int k = 0; k < 40; k++) begin
      int op = $urandom_range(0, 9);
      if (op == 0) strap = 2'($urandom_range(0, 3));
      if (op <= 5)      do_write(good_addr(), 8'($urandom), 8'($urandom));
      else if (op <= 7) do_read(good_addr());
      else              do_write({5'b01011, strap ^ 2'($urandom_range(1, 3))},
                                 8'($urandom), 8'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule